// File: doc/BRIEF.md
# TDM Serial Interface Timing Generator

This block runs the framing of a serial digital port that carries two 8-bit bearer channels in each 8 kHz frame. When it is the timing master, it divides a 30.72 MHz reference clock down to one of five bit rates. It then drives the bit clock, a frame-start sync and a sync that marks the start of the second 8-bit slot. When it is a timing slave, all three timing lines come from outside. The block oversamples the external bit clock and frame-start sync on the reference clock and locks its bit counter to the external frame.

In both roles the block shifts two transmit bytes out on a data line. The data line is driven only during the two channel slots. The block also gathers two receive bytes from the data-in line and raises a one-cycle strobe when both bytes are complete. Configuration inputs choose the rate, the role, whether data is delayed one position behind the sync, and whether the two channels are swapped between the slots. All of them can change at run time.

Top module: `tdm_timing_gen`

## Requirements
- R1: After reset the block drives nothing: `bclk_oe`, `fs_oe`, `dout_oe`, `rx_valid`, `bclk_o`, `rx_b1` and `rx_b2` are all zero.
- R2: In master mode the bit clock period, in reference clocks, is set by `cfg_rate`: 000 gives 120, 001 gives 60, 010 gives 20, 011 gives 15 and 100 gives 12. Codes 101 to 111 behave like 000.
- R3: In master mode the frame-start sync repeats once per frame. A frame is 32, 64, 192, 256 or 320 bit-clock periods for rate codes 000 to 100, and 32 for unused codes.
- R4: In master mode the frame-start sync is high for exactly one bit period. With delayed data off, it rises on the same rising bit-clock edge that starts bit 0, which is also the edge where `dout_oe` rises.
- R5: In master mode the second sync rises eight bit periods after the frame-start sync and is one bit period wide.
- R6: With delayed data on, the master syncs rise one full bit period earlier. The frame-start sync rises at the last bit of the previous frame, and `dout_oe` rises one bit-clock rise after it.
- R7: Frame bits 0 to 7 form the first slot and bits 8 to 15 form the second. Each byte is sent MSB first, and `dout` changes on rising bit-clock edges. `dout_oe` is high for exactly these 16 bits and low for the rest of the frame.
- R8: `din` is sampled on falling bit-clock edges during bits 0 to 15. On the falling edge of bit 15, `rx_b1` and `rx_b2` are loaded and `rx_valid` pulses for one reference clock.
- R9: With `cfg_swap` = 0, the first slot carries `tx_b1`/`rx_b1` and the second carries `tx_b2`/`rx_b2`. With `cfg_swap` = 1 the two channels trade slots.
- R10: In slave mode `bclk_oe`, `fs_oe`, `fs1_o` and `fs2_o` stay low, and the frame follows `fs1_i`. A rising edge of `fs1_i` marks bit 0 when delayed data is off, and the bit before bit 0 when it is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 30.72 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rate | input | 3 | Bit-rate select |
| cfg_master | input | 1 | 1: generate timing, 0: follow external timing |
| cfg_delayed | input | 1 | 1: data starts one bit after the frame sync |
| cfg_swap | input | 1 | 1: exchange the two channels between slots |
| bclk_i | input | 1 | External bit clock (slave) |
| fs1_i | input | 1 | External frame-start sync (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| bclk_oe | output | 1 | Drive enable for the bit clock pin |
| fs1_o | output | 1 | Generated frame-start sync |
| fs2_o | output | 1 | Generated second-slot sync |
| fs_oe | output | 1 | Drive enable for both sync pins |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Drive enable for transmit data |
| tx_b1 | input | 8 | Transmit byte for channel 1 |
| tx_b2 | input | 8 | Transmit byte for channel 2 |
| rx_b1 | output | 8 | Received byte for channel 1 |
| rx_b2 | output | 8 | Received byte for channel 2 |
| rx_valid | output | 1 | One-cycle strobe when both receive bytes are loaded |

## Verification
The hardest case to reach from the ports is slave-mode framing with delayed data. Here the external sync arrives during the last bit of one frame, and the bit counter must be re-seeded to that last position on a falling edge, so that the following rise starts bit 0. The bench reaches it by driving a slow external bit clock and sync from the reference-clock side over three frames. The first frame is left unaligned, the sync then pulls the counter into place, and the transmit and receive words are judged only in the third frame. Master-mode serial data is closed on itself with a loopback, so that the swap mapping on the transmit side and the receive side is checked in the same frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int REF_PER_FRAME = 3840;
  localparam int MAX_DIV       = 120;
  localparam int MAX_BITS      = 320;
  localparam int DIV_W         = $clog2(MAX_DIV + 1);
  localparam int IDX_W         = $clog2(MAX_BITS);

  typedef logic [2:0] rate_t;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // reference clocks per bit for each rate code; unused codes fall back to the slowest rate
  function automatic logic [DIV_W-1:0] rate_divisor(input rate_t r);
    case (r)
      3'b001:  rate_divisor = DIV_W'(60);
      3'b010:  rate_divisor = DIV_W'(20);
      3'b011:  rate_divisor = DIV_W'(15);
      3'b100:  rate_divisor = DIV_W'(12);
      default: rate_divisor = DIV_W'(MAX_DIV);
    endcase
  endfunction

  // bits per 125 us frame, which is the reference clocks per frame over the divisor
  function automatic logic [IDX_W-1:0] rate_bits(input rate_t r);
    case (r)
      3'b001:  rate_bits = IDX_W'(REF_PER_FRAME / 60);
      3'b010:  rate_bits = IDX_W'(REF_PER_FRAME / 20);
      3'b011:  rate_bits = IDX_W'(REF_PER_FRAME / 15);
      3'b100:  rate_bits = IDX_W'(REF_PER_FRAME / 12);
      default: rate_bits = IDX_W'(REF_PER_FRAME / MAX_DIV);
    endcase
  endfunction
endpackage

// File: rtl/tdm_bitclk.sv
module tdm_bitclk
  import tdm_pkg::*;
#(
  parameter int SYNC_N = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  master,
  input  rate_t rate,
  input  logic  bclk_in,
  input  logic  fs_in,
  input  logic  din_in,
  output logic  bclk_out,
  output edge_t edg,
  output logic  fs_smp,
  output logic  din_smp
);
  localparam int AL_N = SYNC_N - 1;

  logic [DIV_W-1:0]  div, half, cnt_q, cnt_d;
  logic              m_rise, m_fall, s_rise, s_fall, bclk_d;
  logic [SYNC_N-1:0] bs_q, bs_d;
  logic [AL_N-1:0]   fs_q, fs_d, ds_q, ds_d;

  always_comb begin
    div    = rate_divisor(rate);
    half   = div >> 1;
    m_rise = master && (cnt_q >= div - DIV_W'(1));
    m_fall = master && (cnt_q == half - DIV_W'(1));
    s_rise = bs_q[AL_N-1] & ~bs_q[AL_N];
    s_fall = ~bs_q[AL_N-1] & bs_q[AL_N];

    if (!master)     cnt_d = '0;
    else if (m_rise) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);

    if (!master)     bclk_d = 1'b0;
    else if (m_rise) bclk_d = 1'b1;
    else if (m_fall) bclk_d = 1'b0;
    else             bclk_d = bclk_out;

    edg.rise = master ? m_rise : s_rise;
    edg.fall = master ? m_fall : s_fall;

    bs_d = {bs_q[SYNC_N-2:0], bclk_in};
    fs_d = {fs_q[AL_N-2:0], fs_in};
    ds_d = {ds_q[AL_N-2:0], din_in};

    fs_smp  = fs_q[AL_N-1];
    din_smp = master ? din_in : ds_q[AL_N-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      bclk_out <= 1'b0;
      bs_q     <= '0;
      fs_q     <= '0;
      ds_q     <= '0;
    end else begin
      cnt_q    <= cnt_d;
      bclk_out <= bclk_d;
      bs_q     <= bs_d;
      fs_q     <= fs_d;
      ds_q     <= ds_d;
    end
  end

  // R2: the generated clock moves only on its own edge enables
  a_r2_bclk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    master && !edg.rise && !edg.fall |=> $stable(bclk_out));

  a_r2_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    master && $past(master) && $stable(rate) |-> cnt_q < DIV_W'(MAX_DIV));
endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             delayed,
  input  rate_t            rate,
  input  edge_t            edg,
  input  logic             fs_smp,
  output logic [IDX_W-1:0] bit_idx,
  output logic [IDX_W-1:0] bit_nxt,
  output logic             frame_start,
  output logic             fs1_out,
  output logic             fs2_out
);
  logic [IDX_W-1:0] len, last, bit_d;
  logic             wrap, fs1_d, fs2_d, fsp_q, fsp_d;

  always_comb begin
    len     = rate_bits(rate);
    last    = len - IDX_W'(1);
    wrap    = bit_idx >= last;
    bit_nxt = wrap ? '0 : bit_idx + IDX_W'(1);

    bit_d = bit_idx;
    fs1_d = fs1_out;
    fs2_d = fs2_out;
    fsp_d = fsp_q;

    if (edg.rise) bit_d = bit_nxt;

    if (master) begin
      if (edg.rise) begin
        fs1_d = delayed ? (bit_nxt == last) : (bit_nxt == '0);
        fs2_d = delayed ? (bit_nxt == IDX_W'(SLOT_W - 1)) : (bit_nxt == IDX_W'(SLOT_W));
      end
    end else begin
      fs1_d = 1'b0;
      fs2_d = 1'b0;
      if (edg.fall) begin
        fsp_d = fs_smp;
        if (fs_smp && !fsp_q) bit_d = delayed ? last : '0;
      end
    end

    frame_start = edg.rise & wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '1;
      fs1_out <= 1'b0;
      fs2_out <= 1'b0;
      fsp_q   <= 1'b0;
    end else begin
      bit_idx <= bit_d;
      fs1_out <= fs1_d;
      fs2_out <= fs2_d;
      fsp_q   <= fsp_d;
    end
  end

  // R4: non-delayed frame sync rises with bit 0
  a_r4_fs1_at_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master) && !$past(delayed) && $rose(fs1_out) |-> bit_idx == '0);

  // R5: second sync marks the first bit of slot two, or the bit before it
  a_r5_fs2_at_slot2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master) && $rose(fs2_out) |->
      bit_idx == ($past(delayed) ? IDX_W'(SLOT_W - 1) : IDX_W'(SLOT_W)));

  // R6: delayed frame sync rises on the last bit of the frame
  a_r6_fs1_early: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master) && $past(delayed) && $rose(fs1_out) |->
      bit_idx == rate_bits($past(rate)) - IDX_W'(1));
endmodule

// File: rtl/tdm_serdes.sv
module tdm_serdes
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int NSLOT  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  edge_t                       edg,
  input  logic [IDX_W-1:0]            bit_idx,
  input  logic [IDX_W-1:0]            bit_nxt,
  input  logic                        frame_start,
  input  logic                        swap,
  input  logic [NSLOT-1:0][SLOT_W-1:0] tx_ch,
  input  logic                        din_smp,
  output logic                        dout,
  output logic                        dout_oe,
  output logic [NSLOT-1:0][SLOT_W-1:0] rx_ch,
  output logic                        rx_valid
);
  localparam int WIN = NSLOT * SLOT_W;
  localparam int BW  = $clog2(SLOT_W);
  localparam int SW  = $clog2(NSLOT) > 0 ? $clog2(NSLOT) : 1;

  logic [NSLOT-1:0][SLOT_W-1:0] tx_map, hold_q, hold_d, src, rx_d, word_slots;
  logic [WIN-1:0]               sh_q, sh_d, word;
  logic                         dout_d, oe_d, valid_d, in_win;
  logic [BW-1:0]                bsel;
  logic [SW-1:0]                ssel;

  // slot g carries channel g, or the mirrored channel when swapped
  for (genvar g = 0; g < NSLOT; g++) begin : g_map
    assign tx_map[g]     = swap ? tx_ch[NSLOT-1-g] : tx_ch[g];
    assign word_slots[g] = word[WIN-1-g*SLOT_W -: SLOT_W];
    assign rx_d[g]       = swap ? word_slots[NSLOT-1-g] : word_slots[g];
  end

  always_comb begin
    src    = frame_start ? tx_map : hold_q;
    hold_d = frame_start ? tx_map : hold_q;
    in_win = bit_nxt < IDX_W'(WIN);
    bsel   = ~bit_nxt[BW-1:0];
    ssel   = bit_nxt[BW +: SW];

    dout_d = dout;
    oe_d   = dout_oe;
    if (edg.rise) begin
      oe_d   = in_win;
      dout_d = in_win ? src[ssel][bsel] : 1'b0;
    end

    word    = {sh_q[WIN-2:0], din_smp};
    sh_d    = sh_q;
    valid_d = 1'b0;
    if (edg.fall && (bit_idx < IDX_W'(WIN))) begin
      sh_d = word;
      if (bit_idx == IDX_W'(WIN - 1)) valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      dout     <= 1'b0;
      dout_oe  <= 1'b0;
      sh_q     <= '0;
      rx_ch    <= '0;
      rx_valid <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      dout     <= dout_d;
      dout_oe  <= oe_d;
      sh_q     <= sh_d;
      rx_valid <= valid_d;
      if (valid_d) rx_ch <= rx_d;
    end
  end

  // R8: receive strobe follows the falling edge of the last slot bit
  a_r8_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_idx) == IDX_W'(WIN - 1));

  // R7: nothing is driven onto the data line while the enable is low
  a_r7_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);
endmodule

// File: rtl/tdm_timing_gen.sv
module tdm_timing_gen
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_rate,
  input  logic              cfg_master,
  input  logic              cfg_delayed,
  input  logic              cfg_swap,
  input  logic              bclk_i,
  input  logic              fs1_i,
  output logic              bclk_o,
  output logic              bclk_oe,
  output logic              fs1_o,
  output logic              fs2_o,
  output logic              fs_oe,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  input  logic [SLOT_W-1:0] tx_b1,
  input  logic [SLOT_W-1:0] tx_b2,
  output logic [SLOT_W-1:0] rx_b1,
  output logic [SLOT_W-1:0] rx_b2,
  output logic              rx_valid
);
  localparam int NSLOT = 2;
  localparam int WIN   = NSLOT * SLOT_W;

  logic [1:0]                   rs_q;
  logic                         rst_sn;
  logic                         oe_d;
  edge_t                        edg;
  logic                         fs_smp, din_smp, frame_start;
  logic [IDX_W-1:0]             bit_idx, bit_nxt;
  logic [NSLOT-1:0][SLOT_W-1:0] tx_ch, rx_ch;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign oe_d = cfg_master;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      bclk_oe <= 1'b0;
      fs_oe   <= 1'b0;
    end else begin
      bclk_oe <= oe_d;
      fs_oe   <= oe_d;
    end
  end

  assign tx_ch[0] = tx_b1;
  assign tx_ch[1] = tx_b2;
  assign rx_b1    = rx_ch[0];
  assign rx_b2    = rx_ch[1];

  tdm_bitclk #(.SYNC_N(3)) u_clk (
    .clk      (clk),
    .rst_n    (rst_sn),
    .master   (cfg_master),
    .rate     (cfg_rate),
    .bclk_in  (bclk_i),
    .fs_in    (fs1_i),
    .din_in   (din),
    .bclk_out (bclk_o),
    .edg      (edg),
    .fs_smp   (fs_smp),
    .din_smp  (din_smp)
  );

  tdm_framer #(.SLOT_W(SLOT_W)) u_frm (
    .clk         (clk),
    .rst_n       (rst_sn),
    .master      (cfg_master),
    .delayed     (cfg_delayed),
    .rate        (cfg_rate),
    .edg         (edg),
    .fs_smp      (fs_smp),
    .bit_idx     (bit_idx),
    .bit_nxt     (bit_nxt),
    .frame_start (frame_start),
    .fs1_out     (fs1_o),
    .fs2_out     (fs2_o)
  );

  tdm_serdes #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_sd (
    .clk         (clk),
    .rst_n       (rst_sn),
    .edg         (edg),
    .bit_idx     (bit_idx),
    .bit_nxt     (bit_nxt),
    .frame_start (frame_start),
    .swap        (cfg_swap),
    .tx_ch       (tx_ch),
    .din_smp     (din_smp),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .rx_ch       (rx_ch),
    .rx_valid    (rx_valid)
  );

  // R10: slave role leaves every timing pin undriven
  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    !cfg_master |=> !bclk_oe && !fs_oe && !fs1_o && !fs2_o && !bclk_o);

  // R7: in master role the data enable drops right after the second slot
  a_r7_oe_window: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(cfg_master) && cfg_master && $fell(dout_oe) |-> bit_idx == IDX_W'(WIN));
endmodule

// File: tb/sim_tdm_timing_gen.sv
module sim_tdm_timing_gen;
  localparam int CLK_PER  = 32;
  localparam int SLV_HALF = 10;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cfg_rate;
  logic       cfg_master, cfg_delayed, cfg_swap;
  logic       bclk_i, fs1_i, din_drv, loop;
  logic       bclk_o, bclk_oe, fs1_o, fs2_o, fs_oe, dout, dout_oe, rx_valid, din;
  logic [7:0] tx_b1, tx_b2, rx_b1, rx_b2;
  logic       pb, pf, p2, po;
  int         total = 0;
  int         bad   = 0;

  always #(CLK_PER/2) clk = ~clk;
  assign din = loop ? dout : din_drv;

  tdm_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_master(cfg_master),
    .cfg_delayed(cfg_delayed), .cfg_swap(cfg_swap), .bclk_i(bclk_i), .fs1_i(fs1_i),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .fs1_o(fs1_o), .fs2_o(fs2_o), .fs_oe(fs_oe),
    .din(din), .dout(dout), .dout_oe(dout_oe), .tx_b1(tx_b1), .tx_b2(tx_b2),
    .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    pb = bclk_o; pf = fs1_o; p2 = fs2_o; po = dout_oe;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_rate = 3'b000; cfg_master = 1'b0; cfg_delayed = 1'b0;
    cfg_swap = 1'b0; bclk_i = 1'b0; fs1_i = 1'b0; din_drv = 1'b0; loop = 1'b0;
    tx_b1 = 8'h00; tx_b2 = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!bclk_oe && !fs_oe, "R1 timing pins undriven", {bclk_oe, fs_oe}, 0);
    chk(!dout_oe && !bclk_o, "R1 data and clock idle", {dout_oe, bclk_o}, 0);
    chk(!rx_valid, "R1 no receive strobe", rx_valid, 0);
    chk(rx_b1 == 8'h00 && rx_b2 == 8'h00, "R1 receive bytes clear", {rx_b1, rx_b2}, 0);
  endtask

  // master rate, frame length and sync placement
  task automatic t_rate(input logic [2:0] code, input int expdiv, input int explen,
                        input logic dly);
    int c, r, fs2_at, oe_at, fall_at;
    cfg_master = 1'b1; cfg_rate = code; cfg_delayed = dly; loop = 1'b0;
    repeat (2) begin
      do step(); while (!(bclk_o && !pb));
    end
    c = 0;
    do begin step(); c++; end while (!(bclk_o && !pb));
    chk(c == expdiv, $sformatf("R2 bit period for code %0d", code), c, expdiv);
    do step(); while (!(fs1_o && !pf));
    do step(); while (!(fs1_o && !pf));
    oe_at = (dout_oe && !po) ? 0 : -1;
    fs2_at = -1; fall_at = -1; r = 0;
    do begin
      step();
      if (bclk_o && !pb) r++;
      if (fs2_o && !p2 && fs2_at < 0) fs2_at = r;
      if (dout_oe && !po && oe_at < 0) oe_at = r;
      if (!fs1_o && pf && fall_at < 0) fall_at = r;
    end while (!(fs1_o && !pf));
    chk(r == explen, $sformatf("R3 frame length for code %0d", code), r, explen);
    chk(fs2_at == 8, "R5 second sync eight bits after frame sync", fs2_at, 8);
    chk(fall_at == 1, "R4 frame sync one bit wide", fall_at, 1);
    if (dly) chk(oe_at == 1, "R6 delayed frame sync one bit before data", oe_at, 1);
    else     chk(oe_at == 0, "R4 frame sync together with bit 0", oe_at, 0);
  endtask

  // master data through a loopback from dout to din
  task automatic t_mdata(input logic dly, input logic swp, input logic [7:0] b1,
                         input logic [7:0] b2);
    logic [15:0] w, exp;
    int n;
    cfg_master = 1'b1; cfg_rate = 3'b000; cfg_delayed = dly; cfg_swap = swp;
    tx_b1 = b1; tx_b2 = b2; loop = 1'b1;
    repeat (2) begin
      do step(); while (!rx_valid);
    end
    w = '0; n = 0;
    do begin
      step();
      if (!bclk_o && pb && dout_oe) begin w = {w[14:0], dout}; n++; end
    end while (!rx_valid);
    exp = swp ? {b2, b1} : {b1, b2};
    chk(w == exp, swp ? "R9 swapped transmit slots" : "R7 transmit word MSB first", w, exp);
    chk(n == 16, "R7 enable high for sixteen bits", n, 16);
    chk(rx_b1 == b1, "R8 loopback channel 1", rx_b1, b1);
    chk(rx_b2 == b2, swp ? "R9 loopback channel 2 swapped" : "R8 loopback channel 2", rx_b2, b2);
  endtask

  // slave: bench drives the bit clock and frame sync
  task automatic t_slave(input logic dly, input logic swp, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [15:0] pat);
    logic [15:0] w, exp;
    logic [7:0]  e1, e2;
    int oebad;
    cfg_master = 1'b0; cfg_rate = 3'b000; cfg_delayed = dly; cfg_swap = swp;
    tx_b1 = b1; tx_b2 = b2; loop = 1'b0;
    w = '0; oebad = 0;
    repeat (4) @(negedge clk);
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < 32; k++) begin
        bclk_i  = 1'b1;
        fs1_i   = dly ? (k == 31) : (k == 0);
        din_drv = (k < 16) ? pat[15-k] : 1'b1;
        repeat (SLV_HALF - 1) @(negedge clk);
        if (f == 2 && k < 16) begin
          w = {w[14:0], dout};
          if (!dout_oe) oebad++;
        end
        if (f == 2 && k == 20) chk(!dout_oe, "R7 enable low outside slots", dout_oe, 0);
        @(negedge clk);
        bclk_i = 1'b0;
        repeat (SLV_HALF) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    exp = swp ? {b2, b1} : {b1, b2};
    e1  = swp ? pat[7:0] : pat[15:8];
    e2  = swp ? pat[15:8] : pat[7:0];
    chk(w == exp, dly ? "R10 delayed slave transmit alignment" : "R10 slave transmit alignment", w, exp);
    chk(oebad == 0, "R7 slave enable over slots", oebad, 0);
    chk(rx_b1 == e1, swp ? "R9 slave receive channel 1" : "R8 slave receive channel 1", rx_b1, e1);
    chk(rx_b2 == e2, "R8 slave receive channel 2", rx_b2, e2);
    chk(!bclk_oe && !fs_oe, "R10 slave leaves timing undriven", {bclk_oe, fs_oe}, 0);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WD_LIMIT, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rate(3'b000, 120,  32, 1'b0);
    t_rate(3'b001,  60,  64, 1'b0);
    t_rate(3'b010,  20, 192, 1'b1);
    t_rate(3'b011,  15, 256, 1'b0);
    t_rate(3'b100,  12, 320, 1'b1);
    t_rate(3'b110, 120,  32, 1'b0);
    t_mdata(1'b0, 1'b0, 8'hA5, 8'h3C);
    t_mdata(1'b0, 1'b1, 8'h81, 8'h7E);
    t_mdata(1'b1, 1'b0, 8'h5A, 8'hC3);
    t_slave(1'b0, 1'b0, 8'h96, 8'h0F, 16'hB4E1);
    t_slave(1'b1, 1'b1, 8'h12, 8'hED, 16'h6C39);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule